// File: doc/BRIEF.md
# Object Collision Latch Array

This block records overlaps between the six graphic objects of a raster video generator: two players, two missiles, a ball and a playfield. Each object arrives as a one-bit pixel input on every pixel clock. During visible video, any pair of objects that draw on the same pixel sets a sticky flag for that pair. The flag stays set until software clears all flags together by writing to a strobe address.

There are fifteen flags. They are packed two to a byte into bits 7 and 6 of eight read registers. Bits 5 to 0 always read as zero. The read address is decoded only on its low four bits, so the register set repeats every 16 bytes. The clear strobe is decoded on the low six bits of the write address, so it repeats every 64 bytes. Read data is registered and comes out one clock after the read request.

Top module: `col_latch_array`

## Requirements
- R1: A synchronous reset clears every flag, and `rd_data` reads 0x00 in the cycle after reset is released.
- R2: When `pix_valid` is high and both objects of a pair are high on the same clock, that pair's flag sets. The flags map to registers (low address nibble) as follows. 0: missile0/player1 in bit 7, missile0/player0 in bit 6. 1: missile1/player0 in bit 7, missile1/player1 in bit 6. 2: player0/playfield in bit 7, player0/ball in bit 6. 3: player1/playfield in bit 7, player1/ball in bit 6. 4: missile0/playfield in bit 7, missile0/ball in bit 6. 5: missile1/playfield in bit 7, missile1/ball in bit 6. 6: ball/playfield in bit 7. 7: player0/player1 in bit 7, missile0/missile1 in bit 6.
- R3: A flag that has been set stays set after the overlap ends, until a clear or a reset.
- R4: While `pix_valid` is low, no flag changes, whatever the object inputs are.
- R5: A single object drawing alone sets no flag.
- R6: A write whose low six address bits equal `CLR_ADDR` (default 0x2C) clears all flags. This holds at every 64-byte mirror of that address. A write to any other address leaves the flags unchanged.
- R7: When a clear write and a new overlap happen on the same clock, the clear wins and all flags read zero afterwards.
- R8: Reads decode only `rd_addr[3:0]`, so addresses that differ only above bit 3 return the same register. Low-nibble values 8 to 15 return 0x00.
- R9: Bits 5 to 0 of `rd_data` are always zero.
- R10: `rd_data` is registered. It presents the selected register in the cycle after `rd_en` is sampled high, and it is 0x00 in the cycle after `rd_en` is sampled low.
- R11: Bit 6 of register 6 always reads zero, even when all objects overlap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_valid | input | 1 | High on visible pixel clocks; qualifies collision sampling |
| obj_p0 | input | 1 | Player 0 pixel |
| obj_p1 | input | 1 | Player 1 pixel |
| obj_m0 | input | 1 | Missile 0 pixel |
| obj_m1 | input | 1 | Missile 1 pixel |
| obj_bl | input | 1 | Ball pixel |
| obj_pf | input | 1 | Playfield pixel |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | WR_ADDR_W | Write address, compared to the clear address on its low six bits |
| rd_en | input | 1 | Read request |
| rd_addr | input | RD_ADDR_W | Read address, decoded on its low four bits |
| rd_data | output | 8 | Registered read data; flags in bits 7 and 6 |

## Verification
Some properties hold on every clock, and the checker tests them there. The low six data bits stay zero. Flags never fall without a clear. Flags stay frozen during blanking. A clear empties the array even when an overlap arrives on the same edge. An idle read port returns zero. The register-to-pair mapping needs separate pixel patterns, each followed by reads of all eight registers, and only the bench's scenarios can show it. The same is true of address mirroring on both the read side and the clear side, and of a mid-run reset.

// File: rtl/col_pkg.sv
package col_pkg;

  localparam int NUM_OBJ    = 6;
  localparam int NUM_REG    = 8;
  localparam int FLAGS_PER  = 2;
  localparam int NUM_SLOT   = NUM_REG * FLAGS_PER;
  localparam int SPARE_SLOT = 12;

  // object positions inside the packed pixel vector
  localparam int OBJ_PF = 0;
  localparam int OBJ_BL = 1;
  localparam int OBJ_M1 = 2;
  localparam int OBJ_M0 = 3;
  localparam int OBJ_P1 = 4;
  localparam int OBJ_P0 = 5;
  localparam int OBJ_NONE = -1;

  typedef logic [NUM_OBJ-1:0]  obj_vec_t;
  typedef logic [NUM_SLOT-1:0] slot_vec_t;

  // slot 2*r+1 feeds bit 7 of register r, slot 2*r feeds bit 6
  function automatic int slot_obj_a(input int slot);
    case (slot)
      0, 1, 8, 9, 14: slot_obj_a = OBJ_M0;
      2, 3, 10, 11:   slot_obj_a = OBJ_M1;
      4, 5, 15:       slot_obj_a = OBJ_P0;
      6, 7:           slot_obj_a = OBJ_P1;
      13:             slot_obj_a = OBJ_BL;
      default:        slot_obj_a = OBJ_NONE;
    endcase
  endfunction

  function automatic int slot_obj_b(input int slot);
    case (slot)
      0, 3:             slot_obj_b = OBJ_P0;
      1, 2, 15:         slot_obj_b = OBJ_P1;
      4, 6, 8, 10:      slot_obj_b = OBJ_BL;
      5, 7, 9, 11, 13:  slot_obj_b = OBJ_PF;
      14:               slot_obj_b = OBJ_M1;
      default:          slot_obj_b = OBJ_NONE;
    endcase
  endfunction

endpackage

// File: rtl/col_pair_detect.sv
module col_pair_detect
  import col_pkg::*;
(
  input  obj_vec_t  pix,
  output slot_vec_t hit
);

  for (genvar s = 0; s < NUM_SLOT; s++) begin : g_slot
    localparam int A = slot_obj_a(s);
    localparam int B = slot_obj_b(s);
    if (A == OBJ_NONE || B == OBJ_NONE) begin : g_spare
      assign hit[s] = 1'b0;
    end else begin : g_pair
      assign hit[s] = pix[A] & pix[B];
    end
  end

endmodule

// File: rtl/col_latch_bank.sv
module col_latch_bank
  import col_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      clr,
  input  logic      sample_en,
  input  slot_vec_t hit,
  output slot_vec_t latch_q
);

  for (genvar s = 0; s < NUM_SLOT; s++) begin : g_latch
    if (s == SPARE_SLOT) begin : g_tie
      assign latch_q[s] = 1'b0;
    end else begin : g_ff
      logic q;
      always_ff @(posedge clk) begin
        if (rst || clr)
          q <= 1'b0;
        else if (sample_en && hit[s])
          q <= 1'b1;
      end
      assign latch_q[s] = q;
    end
  end

endmodule

// File: rtl/col_read_port.sv
module col_read_port
  import col_pkg::*;
#(
  parameter int DEC_W  = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [DEC_W-1:0]  rd_idx,
  input  slot_vec_t         latch_q,
  output logic [DATA_W-1:0] rd_data
);

  localparam int IDX_W = $clog2(NUM_REG);
  localparam int PAD_W = DATA_W - FLAGS_PER;

  logic [FLAGS_PER-1:0] reg_flags [NUM_REG];
  logic [DATA_W-1:0]    sel_data;

  for (genvar r = 0; r < NUM_REG; r++) begin : g_reg
    assign reg_flags[r] = latch_q[FLAGS_PER*r +: FLAGS_PER];
  end

  always_comb begin
    if (int'(rd_idx) < NUM_REG)
      sel_data = {reg_flags[rd_idx[IDX_W-1:0]], {PAD_W{1'b0}}};
    else
      sel_data = '0;
  end

  always_ff @(posedge clk) begin
    if (rst)
      rd_data <= '0;
    else if (rd_en)
      rd_data <= sel_data;
    else
      rd_data <= '0;
  end

endmodule

// File: rtl/col_latch_array.sv
module col_latch_array
  import col_pkg::*;
#(
  parameter int RD_ADDR_W = 8,
  parameter int WR_ADDR_W = 8,
  parameter int RD_DEC_W  = 4,
  parameter int WR_DEC_W  = 6,
  parameter logic [WR_DEC_W-1:0] CLR_ADDR = 6'h2C
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 pix_valid,
  input  logic                 obj_p0,
  input  logic                 obj_p1,
  input  logic                 obj_m0,
  input  logic                 obj_m1,
  input  logic                 obj_bl,
  input  logic                 obj_pf,
  input  logic                 wr_en,
  input  logic [WR_ADDR_W-1:0] wr_addr,
  input  logic                 rd_en,
  input  logic [RD_ADDR_W-1:0] rd_addr,
  output logic [7:0]           rd_data
);

  obj_vec_t  pix;
  slot_vec_t hit;
  slot_vec_t latch_q;
  logic      clr_hit;

  assign pix[OBJ_P0] = obj_p0;
  assign pix[OBJ_P1] = obj_p1;
  assign pix[OBJ_M0] = obj_m0;
  assign pix[OBJ_M1] = obj_m1;
  assign pix[OBJ_BL] = obj_bl;
  assign pix[OBJ_PF] = obj_pf;

  assign clr_hit = wr_en && (wr_addr[WR_DEC_W-1:0] == CLR_ADDR);

  col_pair_detect u_detect (
    .pix (pix),
    .hit (hit)
  );

  col_latch_bank u_bank (
    .clk       (clk),
    .rst       (rst),
    .clr       (clr_hit),
    .sample_en (pix_valid),
    .hit       (hit),
    .latch_q   (latch_q)
  );

  col_read_port #(
    .DEC_W  (RD_DEC_W),
    .DATA_W (8)
  ) u_read (
    .clk     (clk),
    .rst     (rst),
    .rd_en   (rd_en),
    .rd_idx  (rd_addr[RD_DEC_W-1:0]),
    .latch_q (latch_q),
    .rd_data (rd_data)
  );

endmodule

// File: rtl/col_latch_chk.sv
module col_latch_chk
  import col_pkg::*;
#(
  parameter int RD_ADDR_W = 8
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 pix_valid,
  input logic                 obj_p0,
  input logic                 obj_p1,
  input logic                 rd_en,
  input logic [RD_ADDR_W-1:0] rd_addr,
  input logic [7:0]           rd_data,
  input slot_vec_t            latch_q,
  input logic                 clr_hit
);

  // R9
  p_low_bits_zero_r9: assert property (@(posedge clk) disable iff (rst)
    rd_data[5:0] == 6'd0);

  // R7
  p_clear_wins_r7: assert property (@(posedge clk) disable iff (rst)
    clr_hit |=> latch_q == '0);

  // R3
  p_sticky_r3: assert property (@(posedge clk) disable iff (rst)
    !clr_hit |=> (latch_q & $past(latch_q)) == $past(latch_q));

  // R4
  p_blank_frozen_r4: assert property (@(posedge clk) disable iff (rst)
    (!pix_valid && !clr_hit) |=> $stable(latch_q));

  // R2
  p_pair_sets_r2: assert property (@(posedge clk) disable iff (rst)
    (pix_valid && !clr_hit && obj_p0 && obj_p1) |=> latch_q[15]);

  // R10
  p_idle_zero_r10: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> rd_data == 8'd0);

  // R11
  p_spare_bit_r11: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_addr[3:0] == 4'd6) |=> !rd_data[6]);

endmodule

bind col_latch_array col_latch_chk #(
  .RD_ADDR_W (RD_ADDR_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .pix_valid (pix_valid),
  .obj_p0    (obj_p0),
  .obj_p1    (obj_p1),
  .rd_en     (rd_en),
  .rd_addr   (rd_addr),
  .rd_data   (rd_data),
  .latch_q   (latch_q),
  .clr_hit   (clr_hit)
);

// File: tb/tb_col_latch_array.sv
module tb_col_latch_array;

  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] CLR = 8'h2C;
  localparam int NVEC = 18;

  // {pattern p0,p1,m0,m1,bl,pf ; expected flags, bit 2r+1 = reg r bit7, 2r = reg r bit6}
  localparam logic [21:0] VEC [NVEC] = '{
    {6'b110000, 16'h8000}, {6'b001100, 16'h4000}, {6'b011000, 16'h0002},
    {6'b101000, 16'h0001}, {6'b100100, 16'h0008}, {6'b010100, 16'h0004},
    {6'b100001, 16'h0020}, {6'b100010, 16'h0010}, {6'b010001, 16'h0080},
    {6'b010010, 16'h0040}, {6'b001001, 16'h0200}, {6'b001010, 16'h0100},
    {6'b000101, 16'h0800}, {6'b000110, 16'h0400}, {6'b000011, 16'h2000},
    {6'b100000, 16'h0000}, {6'b111111, 16'hEFFF}, {6'b000000, 16'h0000}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pix_valid = 1'b0;
  logic [5:0] pat = 6'd0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_addr = 8'd0;
  logic       rd_en = 1'b0;
  logic [7:0] rd_addr = 8'd0;
  logic [7:0] rd_data;

  int n_checks = 0;
  int n_fail   = 0;
  logic done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  col_latch_array dut (
    .clk (clk), .rst (rst), .pix_valid (pix_valid),
    .obj_p0 (pat[5]), .obj_p1 (pat[4]), .obj_m0 (pat[3]),
    .obj_m1 (pat[2]), .obj_bl (pat[1]), .obj_pf (pat[0]),
    .wr_en (wr_en), .wr_addr (wr_addr),
    .rd_en (rd_en), .rd_addr (rd_addr), .rd_data (rd_data)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic do_read(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    d = rd_data;
    rd_en = 1'b0;
  endtask

  task automatic drive_pix(input logic [5:0] p, input logic v);
    @(negedge clk);
    pat = p; pix_valid = v;
    @(negedge clk);
    pat = 6'd0; pix_valid = 1'b0;
  endtask

  task automatic do_write(input logic [7:0] a);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic check_all(input string req, input logic [15:0] exp);
    logic [7:0] d;
    for (int r = 0; r < 8; r++) begin
      do_read(8'(r), d);
      check(req, d, {exp[2*r+1], exp[2*r], 6'd0});
    end
  endtask

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset rd_data", rd_data, 8'h00);
    check_all("R1 reset flags", 16'h0000);

    // R2 table walk: layout of every pair
    for (int i = 0; i < NVEC; i++) begin
      do_write(CLR);
      drive_pix(VEC[i][21:16], 1'b1);
      check_all("R2 pair layout", VEC[i][15:0]);
    end

    // R5 single object
    do_write(CLR);
    drive_pix(6'b000010, 1'b1);
    check_all("R5 single object", 16'h0000);

    // R3 sticky
    do_write(CLR);
    drive_pix(6'b110000, 1'b1);
    repeat (5) drive_pix(6'b000000, 1'b1);
    do_read(8'd7, d);
    check("R3 sticky", d, 8'h80);

    // R4 blanking ignored
    do_write(CLR);
    drive_pix(6'b111111, 1'b0);
    check_all("R4 blank ignored", 16'h0000);

    // R6 mirrored clear, and non-clear write
    drive_pix(6'b111111, 1'b1);
    do_write(CLR ^ 8'h01);
    do_read(8'd7, d);
    check("R6 other addr ignored", d, 8'hC0);
    do_write(CLR + 8'h40);
    check_all("R6 mirrored clear", 16'h0000);

    // R7 clear beats same-cycle collision
    @(negedge clk);
    wr_en = 1'b1; wr_addr = CLR; pat = 6'b111111; pix_valid = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; pat = 6'd0; pix_valid = 1'b0;
    check_all("R7 clear priority", 16'h0000);

    // R8, R9, R11 with everything set
    drive_pix(6'b111111, 1'b1);
    do_read(8'h17, d);
    check("R8 mirror 0x17", d, 8'hC0);
    do_read(8'hF2, d);
    check("R8 mirror 0xF2", d, 8'hC0);
    do_read(8'h2B, d);
    check("R8 nibble 11 zero", d, 8'h00);
    do_read(8'h08, d);
    check("R8 nibble 8 zero", d, 8'h00);
    do_read(8'h06, d);
    check("R11 spare bit", d, 8'h80);
    check("R9 low bits", d & 8'h3F, 8'h00);

    // R10 latency and idle zero
    @(negedge clk);
    rd_en = 1'b1; rd_addr = 8'd0;
    @(negedge clk);
    rd_en = 1'b0;
    check("R10 one-cycle data", rd_data, 8'hC0);
    @(negedge clk);
    check("R10 idle zero", rd_data, 8'h00);

    // R1 mid-run reset
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 mid reset rd_data", rd_data, 8'h00);
    check_all("R1 mid reset flags", 16'h0000);

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule